// File: doc/BRIEF.md
# Octal DAC Command and Register Controller

This block sits behind a serial receiver and turns each completed 24-bit input word into register and power-state changes for eight converter channels. Every channel keeps two stages of code: a staging register that commands load and an active register whose value drives the converter. Commands can stage a code, make staged codes active, switch channels off, shut the whole chip down, and choose between the on-chip and an off-chip reference. The analog conversion and the serial protocol are outside this block.

The controller also tracks whether the on-chip reference is running and why it stopped. It flags each channel that is coming out of power-down for a settling time measured in system clocks. That time is longer when every channel and the reference were off before the wake-up. Code width (8, 10 or 12 bits), the reset code and the reset reference choice are parameters.

Top module: `octal_dac_ctrl`

## Requirements
- R1: After reset, every staging and active code is zero (RST_MID=0) or 2^(RES-1) (RST_MID=1). All power-down flags and busy flags are clear. The reference select and reference-on outputs both equal RST_INT_REF.
- R2: An accepted word carries the command in bits 23:20 and the channel address in bits 19:16. The code occupies bits 15 down to 16-RES, MSB first. Bits below the code have no effect on any output.
- R3: Command 0000 loads the code into the addressed staging register only. Active codes do not change.
- R4: Command 0001 copies the addressed staging register into its active register and clears that channel's power-down flag. Command 0011 loads the code and makes it active in the same cycle.
- R5: Command 0010 loads the code into the addressed staging register, then copies all eight staging registers to their active registers and clears all power-down flags.
- R6: Addresses 0000 to 0111 pick channels 0 to 7 and 1111 picks every channel. A channel command that carries any other address has no effect.
- R7: Command 0100 sets the addressed channel's power-down flag and ignores the code field. Staging and active codes stay unchanged while a channel is powered down.
- R8: Command 0101 sets every power-down flag and turns the reference off. Command 0110 selects the internal reference and turns it on. Command 0111 selects the external reference and turns the internal one off.
- R9: If the reference was turned off by 0101 while the internal reference was selected, any command that updates an active register turns it back on. After 0111, only 0110 turns it back on.
- R10: An update of a channel whose power-down flag was set raises its busy flag for exactly 10*CLK_PER_US cycles. The time is 12*CLK_PER_US cycles if all eight flags were set and the reference was off before the command. An update of a powered channel raises no busy flag.
- R11: Command 1111, the reserved command codes, and any word presented with word_vld_i low change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_vld_i | input | 1 | One-cycle strobe: word_i holds a complete input word |
| word_i | input | 24 | Command, address and code |
| code_o | output | NCH*RES | Active code of each channel, channel i at bits i*RES +: RES |
| pd_o | output | NCH | Per-channel power-down flag |
| ref_int_o | output | 1 | 1 = internal reference selected |
| ref_on_o | output | 1 | Internal reference running |
| busy_o | output | NCH | Per-channel settling in progress |

## Verification
The hardest state to reach is the long settling delay. It needs every channel powered down and the reference off at the moment of the update, and the reference can be off for two different reasons that behave differently afterwards. Directed sequences drive the chip-down command followed by a single-channel update, and also the external-select command followed by chip-down and a broadcast update. These show both the 48-cycle window and the reference staying off or coming back. A long run of seeded random words then mixes reserved codes and addresses, so that the short and long windows overlap with later updates and power-downs.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;
  typedef enum logic [3:0] {
    CMD_WR         = 4'h0,
    CMD_UPD        = 4'h1,
    CMD_WR_UPD_ALL = 4'h2,
    CMD_WR_UPD     = 4'h3,
    CMD_PD         = 4'h4,
    CMD_PD_CHIP    = 4'h5,
    CMD_REF_INT    = 4'h6,
    CMD_REF_EXT    = 4'h7,
    CMD_NOP        = 4'hF
  } cmd_e;

  localparam logic [3:0] ADDR_ALL = 4'hF;

  typedef struct packed {
    logic wr;
    logic upd_sel;
    logic upd_all;
    logic pd_sel;
    logic pd_all;
    logic ref_int;
    logic ref_ext;
  } op_t;
endpackage

// File: rtl/dacctl_decode.sv
module dacctl_decode
  import dacctl_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           vld_i,
  input  logic [3:0]     cmd_i,
  input  logic [3:0]     addr_i,
  output op_t            op_o,
  output logic [NCH-1:0] hit_o
);
  logic addr_ok;

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit_o[i] = (addr_i == ADDR_ALL) || (addr_i == 4'(i));
  end
  assign addr_ok = |hit_o;

  always_comb begin
    op_o = '0;
    if (vld_i) begin
      case (cmd_e'(cmd_i))
        CMD_WR:         op_o.wr = addr_ok;
        CMD_UPD:        op_o.upd_sel = addr_ok;
        CMD_WR_UPD_ALL: begin op_o.wr = addr_ok; op_o.upd_all = addr_ok; end
        CMD_WR_UPD:     begin op_o.wr = addr_ok; op_o.upd_sel = addr_ok; end
        CMD_PD:         op_o.pd_sel = addr_ok;
        CMD_PD_CHIP:    op_o.pd_all = 1'b1;
        CMD_REF_INT:    op_o.ref_int = 1'b1;
        CMD_REF_EXT:    op_o.ref_ext = 1'b1;
        default:        ;
      endcase
    end
  end
endmodule

// File: rtl/dacctl_chan.sv
module dacctl_chan #(
  parameter int          RES      = 12,
  parameter int          SHORT    = 40,
  parameter int          LONG     = 48,
  parameter logic [RES-1:0] RST_CODE = '0,
  localparam int         DLY_W    = $clog2(LONG + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           upd_i,
  input  logic           pd_i,
  input  logic           long_i,
  input  logic [RES-1:0] data_i,
  output logic [RES-1:0] code_o,
  output logic           pd_o,
  output logic           busy_o
);
  logic [RES-1:0]   inp_q, inp_d, dac_q;
  logic             pd_q;
  logic [DLY_W-1:0] cnt_q;

  assign inp_d = wr_i ? data_i : inp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inp_q <= RST_CODE;
      dac_q <= RST_CODE;
      pd_q  <= 1'b0;
    end else begin
      inp_q <= inp_d;
      if (upd_i) dac_q <= inp_d;
      if (upd_i)     pd_q <= 1'b0;
      else if (pd_i) pd_q <= 1'b1;
    end
  end

  // wake-up timer: loads only when a powered-down channel is updated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (upd_i && pd_q)     cnt_q <= long_i ? DLY_W'(LONG) : DLY_W'(SHORT);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign code_o = dac_q;
  assign pd_o   = pd_q;
  assign busy_o = (cnt_q != '0);

  AST_UPD_CLEARS_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !pd_q); // R4
  AST_PD_KEEPS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_i && !upd_i) |=> $stable(dac_q)); // R7
  AST_BUSY_NEEDS_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(pd_q)); // R10
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DLY_W'(LONG)); // R10
endmodule

// File: rtl/octal_dac_ctrl.sv
module octal_dac_ctrl
  import dacctl_pkg::*;
#(
  parameter int RES         = 12,
  parameter int NCH         = 8,
  parameter int CLK_PER_US  = 4,
  parameter bit RST_MID     = 1'b1,
  parameter bit RST_INT_REF = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_vld_i,
  input  logic [23:0]        word_i,
  output logic [NCH*RES-1:0] code_o,
  output logic [NCH-1:0]     pd_o,
  output logic               ref_int_o,
  output logic               ref_on_o,
  output logic [NCH-1:0]     busy_o
);
  localparam int             SHORT    = 10 * CLK_PER_US;
  localparam int             LONG     = 12 * CLK_PER_US;
  localparam logic [RES-1:0] RST_CODE = RST_MID ? RES'(1) << (RES - 1) : '0;

  op_t            op;
  logic [NCH-1:0] hit;
  logic [RES-1:0] data;
  logic           long_dly, upd_any;
  logic           ref_int_q, ref_on_q;
  logic           unused_low;

  assign data       = word_i[15 -: RES];
  assign unused_low = ^word_i[15-RES:0];

  dacctl_decode #(.NCH(NCH)) u_dec (
    .vld_i (word_vld_i),
    .cmd_i (word_i[23:20]),
    .addr_i(word_i[19:16]),
    .op_o  (op),
    .hit_o (hit)
  );

  // all channels and reference off before this command => long wake-up
  assign long_dly = (&pd_o) && !ref_on_q;
  assign upd_any  = op.upd_all | op.upd_sel;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dacctl_chan #(
      .RES(RES), .SHORT(SHORT), .LONG(LONG), .RST_CODE(RST_CODE)
    ) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (op.wr & hit[i]),
      .upd_i (op.upd_all | (op.upd_sel & hit[i])),
      .pd_i  (op.pd_all | (op.pd_sel & hit[i])),
      .long_i(long_dly),
      .data_i(data),
      .code_o(code_o[i*RES +: RES]),
      .pd_o  (pd_o[i]),
      .busy_o(busy_o[i])
    );
  end

  // ref_on low with ref_int high can only mean chip power-down turned it off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_int_q <= RST_INT_REF;
      ref_on_q  <= RST_INT_REF;
    end else if (op.ref_int) begin
      ref_int_q <= 1'b1;
      ref_on_q  <= 1'b1;
    end else if (op.ref_ext) begin
      ref_int_q <= 1'b0;
      ref_on_q  <= 1'b0;
    end else if (op.pd_all) begin
      ref_on_q  <= 1'b0;
    end else if (upd_any && ref_int_q) begin
      ref_on_q  <= 1'b1;
    end
  end

  assign ref_int_o = ref_int_q;
  assign ref_on_o  = ref_on_q;

  AST_REF_ON_NEEDS_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_on_q |-> ref_int_q); // R8
  AST_EXT_LOCKS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_int_q && !op.ref_int) |=> !ref_on_q); // R9
  AST_CHIP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op.pd_all |=> ((&pd_o) && !ref_on_q)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_i |=> ($stable(code_o) && $stable(ref_int_o))); // R11
endmodule

// File: tb/tb_octal_dac_ctrl.sv
module tb_octal_dac_ctrl;
  localparam int CLK_P = 10;
  localparam int RES   = 12;
  localparam int NCH   = 8;
  localparam int CPU   = 4;
  localparam int SHORT = 10 * CPU;
  localparam int LONG  = 12 * CPU;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               vld = 1'b0;
  logic [23:0]        word = '0;
  logic [NCH*RES-1:0] code;
  logic [NCH-1:0]     pd, busy;
  logic               ref_int, ref_on;

  int n_cmp = 0;
  int n_bad = 0;

  logic [RES-1:0] m_inp [NCH];
  logic [RES-1:0] m_dac [NCH];
  logic           m_pd  [NCH];
  int             m_cnt [NCH];
  logic           m_int, m_on;

  always #(CLK_P/2) clk = ~clk;

  octal_dac_ctrl #(.RES(RES), .NCH(NCH), .CLK_PER_US(CPU), .RST_MID(1'b1), .RST_INT_REF(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_vld_i(vld), .word_i(word),
    .code_o(code), .pd_o(pd), .ref_int_o(ref_int), .ref_on_o(ref_on), .busy_o(busy)
  );

  function automatic logic [23:0] mk(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
    return {c, a, d};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_inp[i] = 12'h800; m_dac[i] = 12'h800; m_pd[i] = 1'b0; m_cnt[i] = 0;
    end
    m_int = 1'b1; m_on = 1'b1;
  endtask

  task automatic model_apply(input logic v, input logic [23:0] w);
    logic [3:0] c, a;
    logic [RES-1:0] d;
    logic ok, all_pd, lng, wr, us, ua, ps, pa, upd;
    c = w[23:20]; a = w[19:16]; d = w[15:4];
    ok = (a == 4'hF) || (a < 4'(NCH));
    all_pd = 1'b1;
    for (int i = 0; i < NCH; i++) all_pd &= m_pd[i];
    lng = all_pd && !m_on;
    wr = v && ok && (c == 4'h0 || c == 4'h2 || c == 4'h3);
    us = v && ok && (c == 4'h1 || c == 4'h3);
    ua = v && ok && (c == 4'h2);
    ps = v && ok && (c == 4'h4);
    pa = v && (c == 4'h5);
    for (int i = 0; i < NCH; i++) begin
      logic h, u;
      h = (a == 4'hF) || (a == 4'(i));
      u = ua || (us && h);
      if (u && m_pd[i]) m_cnt[i] = lng ? LONG : SHORT;
      else if (m_cnt[i] > 0) m_cnt[i]--;
      if (wr && h) m_inp[i] = d;
      if (u) begin m_dac[i] = m_inp[i]; m_pd[i] = 1'b0; end
      else if (pa || (ps && h)) m_pd[i] = 1'b1;
    end
    upd = us || ua;
    if (v && c == 4'h6) begin m_int = 1'b1; m_on = 1'b1; end
    else if (v && c == 4'h7) begin m_int = 1'b0; m_on = 1'b0; end
    else if (pa) m_on = 1'b0;
    else if (upd && m_int) m_on = 1'b1;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    for (int i = 0; i < NCH; i++) begin
      chk(tag, $sformatf("code[%0d]", i), int'(code[i*RES +: RES]), int'(m_dac[i]));
      chk(tag, $sformatf("pd[%0d]", i), int'(pd[i]), int'(m_pd[i]));
      chk(tag, $sformatf("busy[%0d]", i), int'(busy[i]), int'(m_cnt[i] != 0));
    end
    chk(tag, "ref_int", int'(ref_int), int'(m_int));
    chk(tag, "ref_on", int'(ref_on), int'(m_on));
  endtask

  task automatic step(input logic v, input logic [23:0] w, input string tag);
    @(negedge clk);
    vld = v; word = w;
    @(posedge clk);
    model_apply(v, w);
    #1;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 24'h0, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] cmds [12];
    cmds = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hF, 4'h8, 4'hC, 4'h1};
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    compare("R1");
    // R3: staging only
    step(1'b1, mk(4'h0, 4'h1, 16'hABC0), "R3");
    idle(2, "R3");
    // R2: low bits ignored, code MSB-aligned
    step(1'b1, mk(4'h0, 4'h1, 16'h5A3F), "R2");
    step(1'b1, mk(4'h1, 4'h1, 16'hFFFF), "R4");
    step(1'b1, mk(4'h3, 4'h5, 16'h1238), "R4");
    // R5: write one, update all
    step(1'b1, mk(4'h0, 4'h6, 16'h7770), "R5");
    step(1'b1, mk(4'h2, 4'h3, 16'hFED0), "R5");
    // R6: reserved address ignored, broadcast
    step(1'b1, mk(4'h3, 4'h9, 16'h1110), "R6");
    step(1'b1, mk(4'h4, 4'hA, 16'h0000), "R6");
    step(1'b1, mk(4'h3, 4'hF, 16'h2220), "R6");
    // R7: power-down n, data ignored, codes kept
    step(1'b1, mk(4'h0, 4'h2, 16'h9990), "R7");
    step(1'b1, mk(4'h4, 4'h2, 16'h4440), "R7");
    idle(2, "R7");
    // R10: short wake-up
    step(1'b1, mk(4'h1, 4'h2, 16'h0000), "R10");
    idle(SHORT + 3, "R10");
    // R8/R9: chip down then update brings reference back, long wake-up
    step(1'b1, mk(4'h5, 4'h0, 16'hFFFF), "R8");
    step(1'b1, mk(4'h1, 4'h0, 16'h0000), "R9");
    idle(LONG + 3, "R10");
    // R9: external select locks reference off
    step(1'b1, mk(4'h7, 4'h0, 16'h0000), "R8");
    step(1'b1, mk(4'h5, 4'h0, 16'h0000), "R8");
    step(1'b1, mk(4'h3, 4'hF, 16'h3330), "R9");
    idle(LONG + 2, "R10");
    step(1'b1, mk(4'h6, 4'h0, 16'h0000), "R8");
    // R11: nop, reserved command, strobe low
    step(1'b1, mk(4'hF, 4'h0, 16'hAAA0), "R11");
    step(1'b1, mk(4'h9, 4'h0, 16'hBBB0), "R11");
    step(1'b1, mk(4'hE, 4'hF, 16'hCCC0), "R11");
    step(1'b0, mk(4'h3, 4'hF, 16'hDDD0), "R11");
    // seeded random mix
    void'($urandom(32'd2024));
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[31:28] != 4'h0, mk(cmds[r[3:0] % 12], r[7:4], r[23:8]), "R2,R6,R10,R11-rand");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule